// File: doc/BRIEF.md
# Opcode Fetch Sequencer with Halt

This block is the front end of a small 8-bit processor. It runs the opcode-fetch machine cycle and nothing else of instruction execution. On every instruction it copies the program counter into a registered address buffer and reads one opcode byte from a synchronous memory port. It places that byte in an instruction register. The program counter is advanced by a dedicated incrementer while the opcode is still in flight, so the counter already points at the next byte before any decode happens. A stub decoder in a fourth state recognises three classes of code: a halt code, a return code, and everything else, which acts as a no-operation.

On a halt code the sequencer stops fetching and parks in a halt state until an enabled interrupt request arrives. Interrupt entry writes the 16-bit return address to a stack port, high byte first, lowers the stack pointer by two and jumps to a fixed vector. The return address is the byte after the halt, because the counter was advanced during the fetch. A handler that ends in the return code therefore resumes after the halt. Firmware that wants to halt again after each handler loops back to the halt itself. With interrupts disabled, the halt state is never left.

Top module: `opfetch_seq`

## Requirements
- R1: After reset the program counter is 0, the status is fetch (code 0), the stack write strobe and the memory read strobe are low, the interrupt enable register is cleared, and the first fetch reads address 0.
- R2: Each fetch loads the address output from the program counter at the end of the first state, so the address appears one cycle after the instruction starts. The memory read strobe is high only in the second state.
- R3: The instruction register takes the memory data present in the third state. It shows that byte from the fourth (decode) state on.
- R4: The program counter is incremented exactly once per fetch, at the end of the second state, and shows the incremented value in the third state, before decode.
- R5: An instruction that neither halts nor takes an interrupt lasts exactly four cycles, and the next fetch starts at the incremented address.
- R6: The halt code 8'h7E enters the halt state in the cycle after decode. The status is halt (code 1) and no memory read is issued while halted.
- R7: An interrupt request is ignored while the interrupt enable is low, both while halted (the halt persists) and during fetches. The enable input is registered and acts one cycle after it changes.
- R8: When an enabled request is seen while halted, the block writes the return address in two consecutive cycles, high byte to stack pointer minus 1 and then low byte to stack pointer minus 2. The status is interrupt-acknowledge (code 2) in both cycles. The return address is the address after the halt byte.
- R9: After the two stack writes, the stack pointer is lowered by 2 and the next fetch starts at the vector address 16'h0038.
- R10: The request is sampled only in the decode state of an instruction or while halted. A request that is high only during the second state is not taken. A request that is high in the decode state is taken, and it pushes the address of the next instruction.
- R11: The return code 8'hA5 loads the program counter with the most recently pushed return address and raises the stack pointer by 2.
- R12: Any code other than the halt and return codes behaves as a no-operation and the fetch continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 8 | Byte returned by the synchronous memory one cycle after a read |
| irq | input | 1 | Interrupt request level |
| irq_en | input | 1 | Interrupt enable level, registered inside the block |
| mem_addr | output | 16 | Registered address bus driven from the program counter |
| mem_rd | output | 1 | Memory read strobe (second fetch state) |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write data byte |
| ir | output | 8 | Instruction register |
| pc | output | 16 | Program counter |
| status | output | 2 | 0 fetch, 1 halt, 2 interrupt acknowledge |

## Verification
Counting from the start of an instruction, the address is due one cycle later, the incremented counter two cycles later, and the instruction register three cycles later. The next instruction begins four cycles after the start. An enabled request seen at decode or in halt produces the high-byte write in the next cycle, the low-byte write one cycle after that, and a fetch at the vector one cycle later still. The bench advances one clock per step and samples on the falling edge. Every check sits at the step where that count puts the result, and inputs change only on falling edges.

// File: rtl/opf_pkg.sv
package opf_pkg;

  typedef enum logic [2:0] {
    S_T1   = 3'd0,
    S_T2   = 3'd1,
    S_T3   = 3'd2,
    S_T4   = 3'd3,
    S_HALT = 3'd4,
    S_ACK1 = 3'd5,
    S_ACK2 = 3'd6
  } seq_state_t;

  localparam logic [1:0] STAT_FETCH = 2'd0;
  localparam logic [1:0] STAT_HALT  = 2'd1;
  localparam logic [1:0] STAT_INTA  = 2'd2;

  // Bus status code seen by the outside world for a sequencer state.
  function automatic logic [1:0] fn_status(input seq_state_t s);
    logic [1:0] r;
    case (s)
      S_HALT:         r = STAT_HALT;
      S_ACK1, S_ACK2: r = STAT_INTA;
      default:        r = STAT_FETCH;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/opf_incr.sv
// Dedicated program-counter incrementer: bit i toggles when all lower bits are 1.
module opf_incr #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign y[0] = ~a[0];
      end else begin : g_upper
        assign y[i] = a[i] ^ (&a[i-1:0]);
      end
    end
  endgenerate

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] OP_HALT = 8'h7E,
  parameter logic [DW-1:0] OP_RET  = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ir,
  input  logic          irq,
  input  logic          ie,
  output seq_state_t    state,
  output logic          ev_t1,
  output logic          ev_rd,
  output logic          ev_inc,
  output logic          ev_ir_load,
  output logic          ev_ret,
  output logic          ev_push_hi,
  output logic          ev_push_lo
);

  seq_state_t state_q, state_d;
  logic       dec_halt;
  logic       int_ok;
  logic       ev_take_int;

  assign dec_halt    = (state_q == S_T4) && (ir == OP_HALT);
  assign int_ok      = irq && ie;
  assign ev_take_int = int_ok &&
                       (((state_q == S_T4) && !dec_halt) || (state_q == S_HALT));

  assign ev_t1      = (state_q == S_T1);
  assign ev_rd      = (state_q == S_T2);
  assign ev_inc     = (state_q == S_T2);
  assign ev_ir_load = (state_q == S_T3);
  assign ev_ret     = (state_q == S_T4) && (ir == OP_RET);
  assign ev_push_hi = (state_q == S_ACK1);
  assign ev_push_lo = (state_q == S_ACK2);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_T1:   state_d = S_T2;
      S_T2:   state_d = S_T3;
      S_T3:   state_d = S_T4;
      S_T4: begin
        if (dec_halt)         state_d = S_HALT;
        else if (ev_take_int) state_d = S_ACK1;
        else                  state_d = S_T1;
      end
      S_HALT: state_d = ev_take_int ? S_ACK1 : S_HALT;
      S_ACK1: state_d = S_ACK2;
      S_ACK2: state_d = S_T1;
      default: state_d = S_T1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_T1;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // Decode is reached only through the last fetch state.
  assert_decode_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_T4) |-> ($past(state_q) == S_T3));

  // Halt is left only toward interrupt acknowledge.
  assert_halt_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HALT) |=> ((state_q == S_HALT) || (state_q == S_ACK1)));

  // With the enable low the halt state holds.
  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_HALT) && !ie) |=> (state_q == S_HALT));

  // Fetch states never see an acknowledge start; it only follows decode or halt.
  assert_sample_point_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACK1) |-> (($past(state_q) == S_T4) || ($past(state_q) == S_HALT)));

endmodule

// File: rtl/opf_stack.sv
module opf_stack #(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] SP_RESET = 16'h00F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic          push_hi,
  input  logic          push_lo,
  input  logic          pop,
  output logic          stk_we,
  output logic [AW-1:0] stk_addr,
  output logic [DW-1:0] stk_wdata,
  output logic [AW-1:0] ret_addr
);

  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] sp_q;
  logic [AW-1:0] ret_q;

  assign stk_we    = push_hi || push_lo;
  assign stk_addr  = push_hi ? (sp_q - ONE) : (sp_q - TWO);
  assign stk_wdata = push_hi ? pc[AW-1 -: DW] : pc[DW-1:0];
  assign ret_addr  = ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= SP_RESET;
      ret_q <= '0;
    end else if (push_lo) begin
      sp_q  <= sp_q - TWO;
      ret_q <= pc;
    end else if (pop) begin
      sp_q  <= sp_q + TWO;
    end
  end

  // High byte write is always followed by the low byte write.
  assert_push_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_hi |=> push_lo);

  // Low byte lands one address below the high byte.
  assert_push_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_lo |-> (stk_addr == $past(stk_addr) - ONE));

  // Return address stays put between the two writes.
  assert_push_stable_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_lo |-> $stable(pc));

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opf_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] VECTOR   = 16'h0038,
  parameter logic [AW-1:0] SP_RESET = 16'h00F0,
  parameter logic [DW-1:0] OP_HALT  = 8'h7E,
  parameter logic [DW-1:0] OP_RET   = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_rdata,
  input  logic          irq,
  input  logic          irq_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          stk_we,
  output logic [AW-1:0] stk_addr,
  output logic [DW-1:0] stk_wdata,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] pc,
  output logic [1:0]    status
);

  seq_state_t    state;
  logic          ev_t1, ev_rd, ev_inc, ev_ir_load, ev_ret, ev_push_hi, ev_push_lo;
  logic [AW-1:0] pc_q, pc_next_seq, addr_q, ret_addr;
  logic [DW-1:0] ir_q;
  logic          ie_q;

  opf_ctrl #(.DW(DW), .OP_HALT(OP_HALT), .OP_RET(OP_RET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ir(ir_q), .irq(irq), .ie(ie_q),
    .state(state), .ev_t1(ev_t1), .ev_rd(ev_rd), .ev_inc(ev_inc),
    .ev_ir_load(ev_ir_load), .ev_ret(ev_ret),
    .ev_push_hi(ev_push_hi), .ev_push_lo(ev_push_lo)
  );

  opf_incr #(.W(AW)) u_incr (.a(pc_q), .y(pc_next_seq));

  opf_stack #(.AW(AW), .DW(DW), .SP_RESET(SP_RESET)) u_stack (
    .clk(clk), .rst_n(rst_n), .pc(pc_q),
    .push_hi(ev_push_hi), .push_lo(ev_push_lo), .pop(ev_ret),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .ret_addr(ret_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      addr_q <= '0;
      ir_q   <= '0;
      ie_q   <= 1'b0;
    end else begin
      ie_q <= irq_en;
      if (ev_t1)      addr_q <= pc_q;
      if (ev_ir_load) ir_q   <= mem_rdata;
      if (ev_inc)          pc_q <= pc_next_seq;
      else if (ev_push_lo) pc_q <= VECTOR;
      else if (ev_ret)     pc_q <= ret_addr;
    end
  end

  assign mem_addr = addr_q;
  assign mem_rd   = ev_rd;
  assign ir       = ir_q;
  assign pc       = pc_q;
  assign status   = fn_status(state);

  // Counter runs one ahead of the address buffer before decode.
  assert_pc_ahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T3) |-> (pc_q == addr_q + AW'(1)));

  // Instruction register holds the byte the memory returned in the third state.
  assert_ir_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T4) |-> (ir_q == $past(mem_rdata)));

  // No memory read while halted.
  assert_no_read_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_HALT) |-> !mem_rd);

  // After the second stack write the fetch restarts at the vector.
  assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_lo |=> (pc_q == VECTOR));

endmodule

// File: tb/sim_opfetch_seq.sv
`timescale 1ns/1ps
module sim_opfetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        irq = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        stk_we;
  logic [15:0] stk_addr;
  logic [7:0]  stk_wdata;
  logic [7:0]  ir;
  logic [15:0] pc;
  logic [1:0]  status;

  int nchk = 0;
  int nfail = 0;

  localparam logic [7:0]  HALT_OP = 8'h7E;
  localparam logic [7:0]  RET_OP  = 8'hA5;
  localparam logic [15:0] VEC     = 16'h0038;
  localparam logic [15:0] SP0     = 16'h00F0;

  // Table of sequential opcodes at addresses 0..4 (R12: all act as no-ops).
  localparam int NV = 5;
  localparam logic [7:0] PROG [0:NV-1] = '{8'h00, 8'h11, 8'hFF, 8'h00, 8'h42};

  logic [7:0] mem [0:255];

  always #5 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  opfetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .irq(irq), .irq_en(irq_en),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .ir(ir), .pc(pc), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Walk one non-halting instruction starting in its first state.
  task automatic run_instr(input logic [15:0] a, input logic [7:0] op, input string tag);
    chk({tag, " T1 status"}, status, 2'd0);
    chk({tag, " T1 rd"}, mem_rd, 1'b0);
    chk({tag, " T1 pc"}, pc, a);
    step();
    chk({tag, " R2 addr"}, mem_addr, a);
    chk({tag, " R2 rd"}, mem_rd, 1'b1);
    step();
    chk({tag, " R4 pc"}, pc, a + 16'd1);
    chk({tag, " R2 rd off"}, mem_rd, 1'b0);
    step();
    chk({tag, " R3 ir"}, ir, op);
    step();
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < NV; i++) mem[i] = PROG[i];
    mem[5]   = HALT_OP;
    mem[6]   = 8'h00;
    mem[7]   = 8'h00;
    mem[8]   = HALT_OP;
    mem[VEC[7:0]] = RET_OP;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pc", pc, 16'h0000);
    chk("R1 status", status, 2'd0);
    chk("R1 stk_we", stk_we, 1'b0);
    chk("R1 rd", mem_rd, 1'b0);
    chk("R1 addr", mem_addr, 16'h0000);

    // R7: request held high with enable low during fetches; R5/R12 by table
    irq = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run_instr(16'(i), PROG[i], "R12 R5 R7 table");
      chk("R7 no ack in fetch", stk_we, 1'b0);
    end

    // R6: halt at address 5
    chk("R5 pc at halt fetch", pc, 16'd5);
    step(); step(); step();
    chk("R3 ir halt", ir, HALT_OP);
    step();
    chk("R6 status halt", status, 2'd1);
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R7 halt holds", status, 2'd1);
      chk("R6 no read", mem_rd, 1'b0);
      chk("R7 no push", stk_we, 1'b0);
    end

    // R8: enable; registered, so acknowledge starts two steps later
    irq_en = 1'b1;
    step();
    chk("R7 enable delay", status, 2'd1);
    step();
    chk("R8 status ack", status, 2'd2);
    chk("R8 we hi", stk_we, 1'b1);
    chk("R8 addr hi", stk_addr, SP0 - 16'd1);
    chk("R8 data hi", stk_wdata, 8'h00);
    irq = 1'b0;
    step();
    chk("R8 we lo", stk_we, 1'b1);
    chk("R8 addr lo", stk_addr, SP0 - 16'd2);
    chk("R8 data lo after halt", stk_wdata, 8'h06);
    step();
    chk("R9 pc vector", pc, VEC);
    chk("R9 status fetch", status, 2'd0);

    // R11: handler return resumes after the halt
    run_instr(VEC, RET_OP, "R9 R11 vector");
    chk("R11 pc after return", pc, 16'd6);

    // R10: request only in second state is not taken
    chk("R10 T1", pc, 16'd6);
    step();
    irq = 1'b1;
    step();
    irq = 1'b0;
    step();
    step();
    chk("R10 pulse ignored status", status, 2'd0);
    chk("R10 pulse ignored pc", pc, 16'd7);

    // R10: request in decode state is taken, pushes next address
    step(); step();
    irq = 1'b1;
    step();
    chk("R10 T4 still fetch", status, 2'd0);
    step();
    irq = 1'b0;
    chk("R10 ack hi addr", stk_addr, SP0 - 16'd1);
    chk("R10 ack hi data", stk_wdata, 8'h00);
    step();
    chk("R10 ack lo addr", stk_addr, SP0 - 16'd2);
    chk("R10 ack lo data", stk_wdata, 8'h08);
    step();
    chk("R9 pc vector again", pc, VEC);
    irq_en = 1'b0;
    run_instr(VEC, RET_OP, "R11 second return");
    chk("R11 pc after second return", pc, 16'd8);

    // Final halt with interrupts disabled stays forever (R7)
    irq = 1'b1;
    step(); step(); step(); step();
    for (int k = 0; k < 20; k++) step();
    chk("R7 halt forever", status, 2'd1);
    chk("R7 no push forever", stk_we, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule